// File: doc/BRIEF.md
# UART Frame Parity Generator and Checker

This block prepares the bits that sit between the start and stop bits of a UART character. It also checks those bits when a character arrives. A 2-bit length code sets how wide that field is: 7, 8 or 9 bits. When parity is switched on, the field keeps its width. The payload shrinks by one bit, and the parity bit takes the most significant position of the field. A select input chooses even or odd parity.

On the transmit side, a data word is loaded and the block returns the field, ready to be shifted out LSB first, together with the number of bits to send. On the receive side, a sampled field is presented and the block returns the payload with its upper bits cleared, plus a parity error flag. The flag is aligned with the character-valid strobe. Baud timing, start and stop sampling, and buffering belong to the surrounding serializer and deserializer.

Top module: `uart_parity_framer`

## Requirements
- R1: The field width reported on `tx_nbits` is 8 for length code 00, 9 for code 01, 7 for code 10, and 8 for the reserved code 11.
- R2: With parity off, the low `tx_nbits` bits of `tx_word` appear unchanged on `tx_frame`, and every bit at or above `tx_nbits` is 0.
- R3: With parity on, bits below position N-1 of `tx_frame` carry the low N-1 bits of `tx_word`, where N is the field width. The parity bit sits at bit N-1, which is bit 8, 7 or 6. Higher word bits are ignored.
- R4: With `par_odd` = 0, the payload bits plus the parity bit hold an even number of ones. For example, payload 00110101 gets parity 0.
- R5: With `par_odd` = 1, the payload bits plus the parity bit hold an odd number of ones. For example, payload 00110101 gets parity 1.
- R6: `tx_valid` is high exactly in the cycle after each cycle where `tx_load` is high. `tx_frame` and `tx_nbits` are valid with it.
- R7: `rx_char_valid` is high exactly in the cycle after each cycle where `rx_valid` is high. With it, `rx_data` carries the payload bits of `rx_field`, with the parity position and every higher bit cleared.
- R8: With parity on, `rx_par_err` rises together with `rx_char_valid` when the parity recomputed from the payload differs from the bit at the parity position. It is never high without `rx_char_valid`.
- R9: With parity off, `rx_par_err` stays 0 whatever `rx_field` holds.
- R10: While `rst_n` is low at a clock edge, `tx_valid`, `rx_char_valid`, `rx_par_err`, `tx_frame`, `tx_nbits` and `rx_data` are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| len_code | input | 2 | Field width code (00=8, 01=9, 10=7, 11=8) |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| tx_load | input | 1 | Transmit word strobe |
| tx_word | input | 9 | Transmit data word |
| tx_valid | output | 1 | Transmit field valid |
| tx_frame | output | 9 | Field bits, shifted out LSB first |
| tx_nbits | output | 4 | Number of field bits to send |
| rx_valid | input | 1 | Received field strobe |
| rx_field | input | 9 | Received field bits, bit 0 first on the line |
| rx_char_valid | output | 1 | Received character valid |
| rx_data | output | 9 | Received payload, with the parity position and higher bits cleared |
| rx_par_err | output | 1 | Parity error, valid with `rx_char_valid` |

## Verification
The bench builds the block with its default field width of 9 bits. That is the smallest width that holds every length code, so all three field widths and the reserved code are reachable. Each of the three parity-bit positions (bits 6, 7 and 8) is driven under both parity senses. Every received field is sent twice: once as generated and once with its lowest bit flipped. This shows the error flag appearing only when parity is on, and shows the payload returned with its upper bits cleared.

// File: rtl/upf_pkg.sv
// Shared types for the UART parity framer.
// Assumes the field width parameter FIELD_W is at least 9.
package upf_pkg;

    // Length code values; the ordering is fixed by the serial frame format.
    typedef enum logic [1:0] {
        LEN_STD  = 2'b00,
        LEN_WIDE = 2'b01,
        LEN_NARR = 2'b10,
        LEN_RSV  = 2'b11
    } len_code_e;

    // Number of field bits selected by a length code; the reserved code maps to 8.
    function automatic int unsigned field_bits(len_code_e c);
        case (c)
            LEN_WIDE: return 9;
            LEN_NARR: return 7;
            default:  return 8;
        endcase
    endfunction

endpackage

// File: rtl/upf_fmt_decode.sv
// Decodes the length code and parity enable into the field width, the
// payload mask and a one-hot marker for the parity position.
// Assumes FIELD_W >= 9. Purely combinational.
module upf_fmt_decode #(
    parameter int FIELD_W = 9,
    localparam int CNT_W  = $clog2(FIELD_W + 1)
) (
    input  logic [1:0]         len_code,
    input  logic               par_en,
    output logic [CNT_W-1:0]   field_len,
    output logic [FIELD_W-1:0] pay_mask,
    output logic [FIELD_W-1:0] par_onehot
);
    logic [CNT_W-1:0] pay_len;

    // Field width from the code; the payload is one bit shorter when parity is on.
    always_comb begin
        field_len = CNT_W'(upf_pkg::field_bits(upf_pkg::len_code_e'(len_code)));
        pay_len   = field_len - CNT_W'(par_en);
    end

    // One payload-mask bit and one parity-marker bit for each field position.
    for (genvar i = 0; i < FIELD_W; i++) begin : g_pos
        assign pay_mask[i]   = (CNT_W'(i) < pay_len);
        assign par_onehot[i] = par_en && (CNT_W'(i) == pay_len);
    end
endmodule

// File: rtl/upf_parity_tree.sv
// Computes the parity bit over the masked bits of a word.
// With odd = 0 the result makes the total count of ones even; with odd = 1 it
// makes the count odd. Purely combinational.
module upf_parity_tree #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits,
    input  logic [W-1:0] mask,
    input  logic         odd,
    output logic         par
);
    logic [W-1:0] masked;

    // Gate each bit by its mask before the reduction.
    for (genvar i = 0; i < W; i++) begin : g_gate
        assign masked[i] = bits[i] & mask[i];
    end

    assign par = (^masked) ^ odd;
endmodule

// File: rtl/upf_tx_path.sv
// Transmit side: merges the payload and the parity bit into the field and
// registers it, together with the bit count, for one cycle per load.
// Assumes the mask and marker inputs come from upf_fmt_decode.
module upf_tx_path #(
    parameter int FIELD_W = 9,
    localparam int CNT_W  = $clog2(FIELD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] word,
    input  logic [FIELD_W-1:0] pay_mask,
    input  logic [FIELD_W-1:0] par_onehot,
    input  logic [CNT_W-1:0]   field_len,
    input  logic               par_en,
    input  logic               par_odd,
    output logic               tx_valid,
    output logic [FIELD_W-1:0] tx_frame,
    output logic [CNT_W-1:0]   tx_nbits
);
    logic               par_bit;
    logic [FIELD_W-1:0] frame_nxt;

    upf_parity_tree #(.W(FIELD_W)) u_par (
        .bits(word),
        .mask(pay_mask),
        .odd (par_odd),
        .par (par_bit)
    );

    // Place the payload bits and drop the parity bit into its marked position.
    always_comb begin
        frame_nxt = (word & pay_mask) | (par_onehot & {FIELD_W{par_bit}});
    end

    // Register the field for one cycle per load; clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_frame <= '0;
            tx_nbits <= '0;
        end else begin
            tx_valid <= load;
            tx_frame <= load ? frame_nxt : '0;
            tx_nbits <= load ? field_len : '0;
        end
    end

    AST_TX_EVEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && par_en && !par_odd) |=> (^tx_frame) == 1'b0);              // R4
    AST_TX_ODD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && par_en && par_odd) |=> (^tx_frame) == 1'b1);               // R5
    AST_TX_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_valid);                                                 // R6
    AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !tx_valid);                                               // R6
endmodule

// File: rtl/upf_rx_path.sv
// Receive side: splits the received field into payload and parity bit,
// recomputes the parity and registers the payload and the error flag with
// the character-valid strobe. Assumes the decode inputs match the transmitter.
module upf_rx_path #(
    parameter int FIELD_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [FIELD_W-1:0] rx_field,
    input  logic [FIELD_W-1:0] pay_mask,
    input  logic [FIELD_W-1:0] par_onehot,
    input  logic               par_en,
    input  logic               par_odd,
    output logic               rx_char_valid,
    output logic [FIELD_W-1:0] rx_data,
    output logic               rx_par_err
);
    logic calc_par;
    logic recv_par;
    logic err_nxt;

    upf_parity_tree #(.W(FIELD_W)) u_par (
        .bits(rx_field),
        .mask(pay_mask),
        .odd (par_odd),
        .par (calc_par)
    );

    // Pick the received parity bit and compare it with the recomputed one.
    always_comb begin
        recv_par = |(rx_field & par_onehot);
        err_nxt  = par_en && (calc_par != recv_par);
    end

    // Register the payload and the error flag alongside the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_char_valid <= 1'b0;
            rx_data       <= '0;
            rx_par_err    <= 1'b0;
        end else begin
            rx_char_valid <= rx_valid;
            rx_data       <= rx_valid ? (rx_field & pay_mask) : '0;
            rx_par_err    <= rx_valid && err_nxt;
        end
    end

    AST_RX_VALID_AFTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_char_valid);                                        // R7
    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_par_err |-> rx_char_valid);                                      // R8
    AST_NO_ERR_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en) |=> !rx_par_err);                             // R9
endmodule

// File: rtl/uart_parity_framer.sv
// UART frame parity generator and checker top.
// Decodes the frame format once and shares it between the transmit and
// receive paths. Each path has one register stage.
// Assumes FIELD_W >= 9 and that configuration inputs are stable around strobes.
module uart_parity_framer #(
    parameter int FIELD_W = 9,
    localparam int CNT_W  = $clog2(FIELD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         len_code,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               tx_load,
    input  logic [FIELD_W-1:0] tx_word,
    output logic               tx_valid,
    output logic [FIELD_W-1:0] tx_frame,
    output logic [CNT_W-1:0]   tx_nbits,
    input  logic               rx_valid,
    input  logic [FIELD_W-1:0] rx_field,
    output logic               rx_char_valid,
    output logic [FIELD_W-1:0] rx_data,
    output logic               rx_par_err
);
    logic [CNT_W-1:0]   field_len;
    logic [FIELD_W-1:0] pay_mask;
    logic [FIELD_W-1:0] par_onehot;

    upf_fmt_decode #(.FIELD_W(FIELD_W)) u_dec (
        .len_code  (len_code),
        .par_en    (par_en),
        .field_len (field_len),
        .pay_mask  (pay_mask),
        .par_onehot(par_onehot)
    );

    upf_tx_path #(.FIELD_W(FIELD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .word      (tx_word),
        .pay_mask  (pay_mask),
        .par_onehot(par_onehot),
        .field_len (field_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .tx_valid  (tx_valid),
        .tx_frame  (tx_frame),
        .tx_nbits  (tx_nbits)
    );

    upf_rx_path #(.FIELD_W(FIELD_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_field     (rx_field),
        .pay_mask     (pay_mask),
        .par_onehot   (par_onehot),
        .par_en       (par_en),
        .par_odd      (par_odd),
        .rx_char_valid(rx_char_valid),
        .rx_data      (rx_data),
        .rx_par_err   (rx_par_err)
    );

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_nbits >= CNT_W'(7) && tx_nbits <= CNT_W'(9)));      // R1
    AST_ABOVE_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_frame >> tx_nbits) == '0));                        // R2
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !rx_char_valid && !rx_par_err));            // R10
endmodule

// File: tb/tb_uart_parity_framer.sv
`timescale 1ns/1ps
module tb_uart_parity_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] len_code = 2'b00;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       tx_load = 1'b0;
    logic [8:0] tx_word = '0;
    logic       tx_valid;
    logic [8:0] tx_frame;
    logic [3:0] tx_nbits;
    logic       rx_valid = 1'b0;
    logic [8:0] rx_field = '0;
    logic       rx_char_valid;
    logic [8:0] rx_data;
    logic       rx_par_err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_parity_framer dut (
        .clk(clk), .rst_n(rst_n), .len_code(len_code), .par_en(par_en),
        .par_odd(par_odd), .tx_load(tx_load), .tx_word(tx_word),
        .tx_valid(tx_valid), .tx_frame(tx_frame), .tx_nbits(tx_nbits),
        .rx_valid(rx_valid), .rx_field(rx_field),
        .rx_char_valid(rx_char_valid), .rx_data(rx_data), .rx_par_err(rx_par_err)
    );

    // Vector: {len_code, par_en, par_odd, tx_word, expected field, expected count}
    localparam int NV = 12;
    localparam logic [25:0] VECS [NV] = '{
        {2'b00, 1'b0, 1'b0, 9'h1A5, 9'h0A5, 4'd8},
        {2'b01, 1'b0, 1'b0, 9'h1A5, 9'h1A5, 4'd9},
        {2'b10, 1'b0, 1'b0, 9'h1A5, 9'h025, 4'd7},
        {2'b01, 1'b1, 1'b0, 9'h035, 9'h035, 4'd9},
        {2'b01, 1'b1, 1'b1, 9'h035, 9'h135, 4'd9},
        {2'b00, 1'b1, 1'b0, 9'h0FF, 9'h0FF, 4'd8},
        {2'b00, 1'b1, 1'b1, 9'h0FF, 9'h07F, 4'd8},
        {2'b10, 1'b1, 1'b0, 9'h1C1, 9'h041, 4'd7},
        {2'b10, 1'b1, 1'b1, 9'h1C1, 9'h001, 4'd7},
        {2'b11, 1'b0, 1'b0, 9'h1A5, 9'h0A5, 4'd8},
        {2'b11, 1'b1, 1'b0, 9'h000, 9'h000, 4'd8},
        {2'b00, 1'b1, 1'b0, 9'h035, 9'h035, 4'd8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] pay_mask_of(input logic [1:0] lc, input logic pe);
        int fl = (lc == 2'b01) ? 9 : ((lc == 2'b10) ? 7 : 8);
        int pl = fl - int'(pe);
        return 9'((1 << pl) - 1);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R10: reset dominates active strobes
        tx_load = 1'b1; rx_valid = 1'b1; tx_word = 9'h1FF; rx_field = 9'h1FF; par_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 tx_valid", 32'(tx_valid), 0);
        chk("R10 rx_char_valid", 32'(rx_char_valid), 0);
        chk("R10 rx_par_err", 32'(rx_par_err), 0);
        chk("R10 tx_frame", 32'(tx_frame), 0);
        chk("R10 tx_nbits", 32'(tx_nbits), 0);
        chk("R10 rx_data", 32'(rx_data), 0);
        tx_load = 1'b0; rx_valid = 1'b0; par_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: transmit, receive intact, receive with bit 0 flipped
        for (int k = 0; k < NV; k++) begin
            logic [25:0] v = VECS[k];
            logic [8:0] ef = v[12:4];
            logic [8:0] m = pay_mask_of(v[25:24], v[23]);
            string ptag = v[23] ? (v[22] ? "R5" : "R4") : "R2";
            len_code = v[25:24]; par_en = v[23]; par_odd = v[22]; tx_word = v[21:13];
            tx_load = 1'b1; rx_valid = 1'b1; rx_field = ef;
            @(negedge clk);
            chk("R6 tx_valid", 32'(tx_valid), 1);
            chk(ptag, 32'(tx_frame), 32'(ef));
            chk("R1 tx_nbits", 32'(tx_nbits), 32'(v[3:0]));
            if (v[23]) chk("R3 payload", 32'(tx_frame & m), 32'(v[21:13] & m));
            chk("R7 rx_char_valid", 32'(rx_char_valid), 1);
            chk("R7 rx_data", 32'(rx_data), 32'(ef & m));
            chk("R8 no error on intact", 32'(rx_par_err), 0);
            tx_load = 1'b0; rx_field = ef ^ 9'h001;
            @(negedge clk);
            chk("R6 tx_valid low", 32'(tx_valid), 0);
            chk(v[23] ? "R8 flip flagged" : "R9 flip ignored", 32'(rx_par_err), 32'(v[23]));
            chk("R7 rx_data flipped", 32'(rx_data), 32'((ef ^ 9'h001) & m));
            rx_valid = 1'b0;
            @(negedge clk);
            chk("R7 rx_char_valid low", 32'(rx_char_valid), 0);
            chk("R8 err low without valid", 32'(rx_par_err), 0);
        end

        // R9: parity off, fields of all sorts never flag
        par_en = 1'b0; len_code = 2'b01;
        for (int k = 0; k < 4; k++) begin
            rx_field = 9'(9'h0F3 * (k + 1)); rx_valid = 1'b1;
            @(negedge clk);
            chk("R9 no error with parity off", 32'(rx_par_err), 0);
        end
        rx_valid = 1'b0;

        // R3: parity bit at bit 8 wrong only, payload intact
        par_en = 1'b1; par_odd = 1'b0; len_code = 2'b01;
        rx_field = 9'h135; rx_valid = 1'b1;
        @(negedge clk);
        chk("R3 parity position flagged", 32'(rx_par_err), 1);
        chk("R3 rx_data parity cleared", 32'(rx_data), 32'h035);
        rx_valid = 1'b0;

        // R10: reset in mid-run with a load pending
        tx_load = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid-run tx_valid", 32'(tx_valid), 0);
        tx_load = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule